// File: doc/BRIEF.md
# Vectorised Windowed Reduction Engine

This block reduces a rectangular window of a feature map to one value per output pixel, for a whole vector of channels at a time. Every address in the feature buffer holds one vector of `LANES` channels, and each lane is reduced on its own. No weights are involved: the same engine serves as max-pool, min-pool, sum-pool or rectified activation. The window size and the opcode together pick the function. A 1×1 window gives an elementwise operation, and a k×m window gives a k×m pooling.

A command carries the following fields:

- the input and output base addresses
- the row pitch of the input map
- the output height and width
- the window height and width
- a vertical and a horizontal stride
- a two-bit opcode

After a command is accepted, the engine issues one vector read per cycle with no gaps. It walks output pixels row by row, and within each pixel it walks the window row by row. It writes one result vector when each pixel's window is complete. A single-cycle `done` marks the final write.

The feature buffer read port is synchronous: data for a read issued in one cycle is presented in the next cycle.

Top module: `winred_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `rd_en`, `wr_en` and `done` are 0.
- R2: A command is taken in a cycle where both `cmd_valid` and `cmd_ready` are 1. `cmd_ready` is 0 from the next cycle until the cycle after `done`, and `cmd_valid` has no effect while `cmd_ready` is 0.
- R3: Reads run on consecutive cycles starting the cycle after acceptance, oy*ow*wh*ww of them in total. The order is output row oy, then output column ox, then window row r, then window column s, each from 0 upward. Each read address is in_base + (oy*stride_y + r)*in_width + ox*stride_x + s, modulo 2^AW.
- R4: Opcode 00 gives the signed maximum of the window in each lane.
- R5: Opcode 01 gives the signed minimum of the window in each lane.
- R6: Opcode 10 gives the sum of the window in each lane, wrapped modulo 2^DW.
- R7: Opcode 11 gives the larger of zero and the signed window maximum in each lane. With a 1×1 window this is an elementwise ReLU.
- R8: Exactly one write occurs per output pixel, two cycles after that pixel's last read. Its address is out_base + oy*out_w + ox.
- R9: `done` is a one-cycle pulse that coincides with the final write of a command. `cmd_ready` returns to 1 in the next cycle.
- R10: Lane i occupies bits [i*DW +: DW] of both `rd_data` and `wr_data`. Lane i of each result depends only on lane i of the vectors that were read.
- R11: A command with a 1×1 window and a 1×1 output performs one read, one write two cycles later, and `done` with that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Reduction opcode |
| cmd_in_base | input | AW | Input map base address |
| cmd_out_base | input | AW | Output map base address |
| cmd_in_width | input | DIM_W | Input row pitch in vectors |
| cmd_out_h | input | DIM_W | Output rows (at least 1) |
| cmd_out_w | input | DIM_W | Output columns (at least 1) |
| cmd_win_h | input | DIM_W | Window rows (at least 1) |
| cmd_win_w | input | DIM_W | Window columns (at least 1) |
| cmd_stride_y | input | STR_W | Vertical stride |
| cmd_stride_x | input | STR_W | Horizontal stride |
| rd_en | output | 1 | Feature buffer read request |
| rd_addr | output | AW | Read address |
| rd_data | input | LANES*DW | Read vector, one cycle after the request |
| wr_en | output | 1 | Feature buffer write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | LANES*DW | Result vector |
| done | output | 1 | Final write of the command |

## Verification
Two things share a cycle while the engine runs. The first is that a pixel's result write falls in the same cycle as the reads for the following pixel's window. The second is that the command's final write coincides with `done`. Both are provoked by windows of one, four and six elements, so that write cycles land in the middle of the read stream, and by a 1×1 single-pixel command where the first and last element are the same read. A reference model in the bench builds, at acceptance, the cycle of every read, write and `done`. It compares each port against that schedule on every clock, so a write or pulse one cycle early or late is reported.

// File: rtl/winred_pkg.sv
package winred_pkg;
   typedef enum logic [1:0] {
      OP_MAX  = 2'b00,
      OP_MIN  = 2'b01,
      OP_ADD  = 2'b10,
      OP_RELU = 2'b11
   } red_op_e;
endpackage

// File: rtl/winred_seq.sv
// Address walker: output pixel row-major, window row-major inside each pixel.
module winred_seq #(
   parameter int AW    = 12,
   parameter int DIM_W = 6,
   parameter int STR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    c_in_base,
   input  logic [AW-1:0]    c_out_base,
   input  logic [DIM_W-1:0] c_in_w,
   input  logic [DIM_W-1:0] c_out_h,
   input  logic [DIM_W-1:0] c_out_w,
   input  logic [DIM_W-1:0] c_win_h,
   input  logic [DIM_W-1:0] c_win_w,
   input  logic [STR_W-1:0] c_sy,
   input  logic [STR_W-1:0] c_sx,
   output logic             rd_en,
   output logic [AW-1:0]    rd_addr,
   output logic             el_first,
   output logic             el_last,
   output logic             el_final,
   output logic [AW-1:0]    pix_addr
);
   localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

   logic             run;
   logic [DIM_W-1:0] ox, oy, wr, ws;
   logic [DIM_W-1:0] in_w_q, oh_q, ow_q, wh_q, ww_q;
   logic [STR_W-1:0] sy_q, sx_q;
   logic [AW-1:0]    in_base_q;
   logic [AW-1:0]    row, col;
   logic             s_end, r_end, x_end, y_end;

   assign s_end = (ws == ww_q - ONE);
   assign r_end = (wr == wh_q - ONE);
   assign x_end = (ox == ow_q - ONE);
   assign y_end = (oy == oh_q - ONE);

   always_comb begin
      row     = AW'(oy) * AW'(sy_q) + AW'(wr);
      col     = AW'(ox) * AW'(sx_q) + AW'(ws);
      rd_addr = in_base_q + row * AW'(in_w_q) + col;
   end

   assign rd_en    = run;
   assign el_first = (wr == '0) && (ws == '0);
   assign el_last  = s_end && r_end;
   assign el_final = s_end && r_end && x_end && y_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run       <= 1'b0;
         ox        <= '0;
         oy        <= '0;
         wr        <= '0;
         ws        <= '0;
         in_w_q    <= '0;
         oh_q      <= '0;
         ow_q      <= '0;
         wh_q      <= '0;
         ww_q      <= '0;
         sy_q      <= '0;
         sx_q      <= '0;
         in_base_q <= '0;
         pix_addr  <= '0;
      end else if (start) begin
         run       <= 1'b1;
         ox        <= '0;
         oy        <= '0;
         wr        <= '0;
         ws        <= '0;
         in_w_q    <= c_in_w;
         oh_q      <= c_out_h;
         ow_q      <= c_out_w;
         wh_q      <= c_win_h;
         ww_q      <= c_win_w;
         sy_q      <= c_sy;
         sx_q      <= c_sx;
         in_base_q <= c_in_base;
         pix_addr  <= c_out_base;
      end else if (run) begin
         if (!s_end) begin
            ws <= ws + ONE;
         end else begin
            ws <= '0;
            if (!r_end) begin
               wr <= wr + ONE;
            end else begin
               wr       <= '0;
               pix_addr <= pix_addr + AW'(1);
               if (!x_end) begin
                  ox <= ox + ONE;
               end else begin
                  ox <= '0;
                  if (y_end) run <= 1'b0;
                  else       oy  <= oy + ONE;
               end
            end
         end
      end
   end
endmodule

// File: rtl/winred_lane.sv
// One channel lane: accumulator seeded by the first window element.
module winred_lane
   import winred_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          first,
   input  red_op_e       op,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] acc
);
   logic signed [DW-1:0] a, d, nxt;

   always_comb begin
      a = $signed(acc);
      d = $signed(din);
      if (first) begin
         nxt = (op == OP_RELU && d < 0) ? '0 : d;
      end else begin
         unique case (op)
            OP_MIN:  nxt = (d < a) ? d : a;
            OP_ADD:  nxt = a + d;
            default: nxt = (d > a) ? d : a;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= nxt;
   end
endmodule

// File: rtl/winred_engine.sv
module winred_engine
   import winred_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 8,
   parameter int AW    = 12,
   parameter int DIM_W = 6,
   parameter int STR_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [1:0]          cmd_op,
   input  logic [AW-1:0]       cmd_in_base,
   input  logic [AW-1:0]       cmd_out_base,
   input  logic [DIM_W-1:0]    cmd_in_width,
   input  logic [DIM_W-1:0]    cmd_out_h,
   input  logic [DIM_W-1:0]    cmd_out_w,
   input  logic [DIM_W-1:0]    cmd_win_h,
   input  logic [DIM_W-1:0]    cmd_win_w,
   input  logic [STR_W-1:0]    cmd_stride_y,
   input  logic [STR_W-1:0]    cmd_stride_x,
   output logic                rd_en,
   output logic [AW-1:0]       rd_addr,
   input  logic [LANES*DW-1:0] rd_data,
   output logic                wr_en,
   output logic [AW-1:0]       wr_addr,
   output logic [LANES*DW-1:0] wr_data,
   output logic                done
);
   localparam int VW = LANES * DW;

   if (LANES < 1) begin : g_bad_lanes
      $error("winred_engine: LANES must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("winred_engine: DW must be at least 2");
   end
   if (AW < 2 || DIM_W < 1 || STR_W < 1) begin : g_bad_dims
      $error("winred_engine: address, dimension or stride width too small");
   end

   logic    busy, accept;
   red_op_e op_q;
   logic    s_first, s_last, s_final;
   logic [AW-1:0] s_pix;
   logic    d_vld, d_first, d_last, d_final;
   logic [AW-1:0] d_pix;
   logic [VW-1:0] acc_vec;

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && !busy;

   winred_seq #(.AW(AW), .DIM_W(DIM_W), .STR_W(STR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .c_in_base  (cmd_in_base),
      .c_out_base (cmd_out_base),
      .c_in_w     (cmd_in_width),
      .c_out_h    (cmd_out_h),
      .c_out_w    (cmd_out_w),
      .c_win_h    (cmd_win_h),
      .c_win_w    (cmd_win_w),
      .c_sy       (cmd_stride_y),
      .c_sx       (cmd_stride_x),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .el_first   (s_first),
      .el_last    (s_last),
      .el_final   (s_final),
      .pix_addr   (s_pix)
   );

   // Metadata aligned with the read data returning one cycle later.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         op_q    <= OP_MAX;
         d_vld   <= 1'b0;
         d_first <= 1'b0;
         d_last  <= 1'b0;
         d_final <= 1'b0;
         d_pix   <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         done    <= 1'b0;
      end else begin
         if (accept) begin
            busy <= 1'b1;
            op_q <= red_op_e'(cmd_op);
         end else if (done) begin
            busy <= 1'b0;
         end
         d_vld   <= rd_en;
         d_first <= s_first;
         d_last  <= s_last;
         d_final <= s_final;
         d_pix   <= s_pix;
         wr_en   <= d_vld && d_last;
         wr_addr <= d_pix;
         done    <= d_vld && d_final;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      winred_lane #(.DW(DW)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (d_vld),
         .first (d_first),
         .op    (op_q),
         .din   (rd_data[i*DW +: DW]),
         .acc   (acc_vec[i*DW +: DW])
      );
   end

   assign wr_data = acc_vec;
endmodule

// File: rtl/winred_chk.sv
module winred_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic rd_en,
   input logic wr_en,
   input logic done
);
   p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   p_read_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !cmd_ready);

   p_write_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rd_en, 2));

   p_done_with_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_en);

   p_ready_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind winred_engine winred_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .done      (done)
);

// File: tb/winred_engine_tb_top.sv
`timescale 1ns/1ps
module winred_engine_tb_top;
   localparam int LANES = 16;
   localparam int DW    = 8;
   localparam int AW    = 12;
   localparam int DIM_W = 6;
   localparam int STR_W = 3;
   localparam int VW    = LANES * DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             cmd_valid = 1'b0;
   logic             cmd_ready;
   logic [1:0]       cmd_op = '0;
   logic [AW-1:0]    cmd_in_base = '0, cmd_out_base = '0;
   logic [DIM_W-1:0] cmd_in_width = '0, cmd_out_h = '0, cmd_out_w = '0;
   logic [DIM_W-1:0] cmd_win_h = '0, cmd_win_w = '0;
   logic [STR_W-1:0] cmd_stride_y = '0, cmd_stride_x = '0;
   logic             rd_en, wr_en, done;
   logic [AW-1:0]    rd_addr, wr_addr;
   logic [VW-1:0]    rd_data = '0;
   logic [VW-1:0]    wr_data;

   winred_engine #(.LANES(LANES), .DW(DW), .AW(AW), .DIM_W(DIM_W), .STR_W(STR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_in_base(cmd_in_base), .cmd_out_base(cmd_out_base),
      .cmd_in_width(cmd_in_width), .cmd_out_h(cmd_out_h), .cmd_out_w(cmd_out_w),
      .cmd_win_h(cmd_win_h), .cmd_win_w(cmd_win_w),
      .cmd_stride_y(cmd_stride_y), .cmd_stride_x(cmd_stride_x),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // Feature buffer with one-cycle read latency.
   logic [VW-1:0] mem [0:(1<<AW)-1];

   function automatic logic [DW-1:0] pat(int addr, int lane);
      return DW'(addr * 29 + lane * 53 + 7 + addr * lane);
   endfunction

   initial begin
      for (int a = 0; a < (1 << AW); a++)
         for (int l = 0; l < LANES; l++)
            mem[a][l*DW +: DW] = pat(a, l);
   end

   always @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // Reference schedule
   int            rq_cyc[$];
   int            rq_addr[$];
   int            wq_cyc[$];
   int            wq_addr[$];
   logic [VW-1:0] wq_data[$];
   string         wq_tag[$];
   int            done_cyc = -1;
   int            busy_from = 1;
   int            busy_to = 0;

   task automatic fail(string req, string what, longint act, longint exp);
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
   endtask

   always @(posedge clk) begin
      if (rst_n && cmd_valid && cmd_ready) begin
         automatic int a   = cyc;
         automatic int op  = int'(cmd_op);
         automatic int oh  = int'(cmd_out_h), ow = int'(cmd_out_w);
         automatic int wh  = int'(cmd_win_h), ww = int'(cmd_win_w);
         automatic int win = wh * ww;
         automatic int j   = 0;
         automatic int k   = 0;
         automatic string tag = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R6" : "R7";
         for (int oy = 0; oy < oh; oy++) begin
            for (int ox = 0; ox < ow; ox++) begin
               logic signed [DW-1:0] acc [LANES];
               logic [VW-1:0] res;
               for (int r = 0; r < wh; r++) begin
                  for (int s = 0; s < ww; s++) begin
                     automatic int ad = (int'(cmd_in_base) + (oy * int'(cmd_stride_y) + r) * int'(cmd_in_width)
                                        + ox * int'(cmd_stride_x) + s) % (1 << AW);
                     rq_cyc.push_back(a + 1 + j);
                     rq_addr.push_back(ad);
                     j++;
                     for (int l = 0; l < LANES; l++) begin
                        automatic logic signed [DW-1:0] v = $signed(pat(ad, l));
                        if (r == 0 && s == 0)       acc[l] = (op == 3 && v < 0) ? '0 : v;
                        else if (op == 1)           acc[l] = (v < acc[l]) ? v : acc[l];
                        else if (op == 2)           acc[l] = acc[l] + v;
                        else                        acc[l] = (v > acc[l]) ? v : acc[l];
                     end
                  end
               end
               for (int l = 0; l < LANES; l++) res[l*DW +: DW] = acc[l];
               wq_cyc.push_back(a + (k + 1) * win + 2);
               wq_addr.push_back((int'(cmd_out_base) + oy * ow + ox) % (1 << AW));
               wq_data.push_back(res);
               wq_tag.push_back(tag);
               k++;
            end
         end
         done_cyc  = a + j + 2;
         busy_from = a + 1;
         busy_to   = a + j + 2;
      end
      cyc <= cyc + 1;
   end

   // Compare against the schedule every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && cyc > 1) begin
         automatic logic exp_ready = !(cyc >= busy_from && cyc <= busy_to);
         automatic logic exp_rd    = (rq_cyc.size() > 0) && (rq_cyc[0] == cyc);
         automatic logic exp_wr    = (wq_cyc.size() > 0) && (wq_cyc[0] == cyc);
         checks++;
         if (cmd_ready !== exp_ready) fail("R2/R9", "cmd_ready", cmd_ready, exp_ready);
         checks++;
         if (rd_en !== exp_rd) fail("R3", "rd_en", rd_en, exp_rd);
         if (exp_rd) begin
            checks++;
            if (rd_addr !== AW'(rq_addr[0])) fail("R3", "rd_addr", rd_addr, rq_addr[0]);
            void'(rq_cyc.pop_front());
            void'(rq_addr.pop_front());
         end
         checks++;
         if (wr_en !== exp_wr) fail("R8", "wr_en", wr_en, exp_wr);
         if (exp_wr) begin
            checks++;
            if (wr_addr !== AW'(wq_addr[0])) fail("R8", "wr_addr", wr_addr, wq_addr[0]);
            checks++;
            if (wr_data !== wq_data[0]) begin
               errors++;
               $display("FAIL %s/R10 wr_data: actual %h expected %h (cycle %0d)",
                        wq_tag[0], wr_data, wq_data[0], cyc);
            end
            void'(wq_cyc.pop_front());
            void'(wq_addr.pop_front());
            void'(wq_data.pop_front());
            void'(wq_tag.pop_front());
         end
         checks++;
         if (done !== (cyc == done_cyc)) fail("R9", "done", done, cyc == done_cyc);
      end
   end

   task automatic issue(int op, int inb, int outb, int inw, int oh, int ow,
                        int wh, int ww, int sy, int sx);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      #1;
      cmd_op = 2'(op); cmd_in_base = AW'(inb); cmd_out_base = AW'(outb);
      cmd_in_width = DIM_W'(inw); cmd_out_h = DIM_W'(oh); cmd_out_w = DIM_W'(ow);
      cmd_win_h = DIM_W'(wh); cmd_win_w = DIM_W'(ww);
      cmd_stride_y = STR_W'(sy); cmd_stride_x = STR_W'(sx);
      cmd_valid = 1'b1;
      @(negedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      checks++;
      if (cmd_ready !== 1'b1 || rd_en !== 1'b0 || wr_en !== 1'b0 || done !== 1'b0)
         fail("R1", "reset outputs", {cmd_ready, rd_en, wr_en, done}, 4'b1000);
      rst_n = 1'b1;

      // R7: elementwise ReLU, 1x1 window
      issue(3, 0, 2048, 4, 4, 4, 1, 1, 1, 1);
      // R4: 2x2 max-pool, stride 2
      issue(0, 16, 2100, 8, 4, 4, 2, 2, 2, 2);
      // R2: offer a different command while busy; it must have no effect
      @(negedge clk); #1;
      cmd_op = 2'd2; cmd_in_base = AW'(900); cmd_out_base = AW'(3000);
      cmd_out_h = 6'd1; cmd_out_w = 6'd1; cmd_win_h = 6'd1; cmd_win_w = 6'd1;
      cmd_valid = 1'b1;
      repeat (4) @(negedge clk);
      #1 cmd_valid = 1'b0;
      // R5: 3x2 min window, stride 1
      issue(1, 100, 2200, 6, 2, 3, 3, 2, 1, 1);
      // R6: 2x3 sum window, stride y 2 x 1, wrapping
      issue(2, 200, 2300, 7, 2, 2, 2, 3, 2, 1);
      // R11: single element, single pixel, issued back to back
      issue(0, 300, 2400, 1, 1, 1, 1, 1, 1, 1);
      // R7: max with zero over a 2x2 window
      issue(3, 400, 2500, 4, 2, 2, 2, 2, 2, 2);

      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      checks++;
      if (rq_cyc.size() != 0 || wq_cyc.size() != 0)
         fail("R8", "pending events", rq_cyc.size() + wq_cyc.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule